// File: doc/BRIEF.md
# Serial Receive Start-Word Capture Engine

This block receives a serial bit stream and the bit clock that comes with it from an external PHY. Both arrive asynchronously and are brought into the system clock domain through a short flop chain. Each bit is taken on a detected rising edge of the synchronised receive clock. While reception is armed, the engine watches the sampled bits for a 16-bit start-of-frame word. Bits seen before that word are discarded. Once the word has matched, every following bit is packed into bytes, least significant bit first, and the bytes are written into a small receive FIFO.

The FIFO drains through a valid/ready read port. `rd_valid` is high whenever at least one byte is held, so it also serves as the request line for an external DMA mover. A byte transfers on any cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the head byte is held unchanged. Back-pressure cannot reach the serial side. When the FIFO is full, further bytes are dropped and a sticky overflow flag records the loss.

Reception is armed only when three conditions hold together: software has enabled it, no transmit is in progress, and the power state asks the device to stay awake. An end-of-frame or abort pulse returns the engine to the search state. So does losing any of the three arming conditions. The bit clock may change rate at any point, including in the middle of a frame. No setting has to change for this.

Top module: `rx_sfd_capture`

## Requirements
- R1: After reset, `rd_valid` is 0, `ovf_flag` is 0 and `in_frame` is 0.
- R2: The engine is armed only while `rx_en`=1, `tx_busy`=0 and `pwr_awake`=1. While it is not armed, no bit is stored and `in_frame` is 0 one cycle later. If arming is lost in the middle of a frame, the engine goes back to searching.
- R3: The start word is 16'hF3A0, received bit 0 first. `in_frame` rises only after all 16 bits have matched. A pattern that differs in any single bit is not accepted.
- R4: No bit received before the start word is matched is stored. The first bit after the word becomes bit 0 of the first stored byte.
- R5: Bytes are assembled least significant bit first. One byte is written to the FIFO after every 8 bits accepted.
- R6: A bit is sampled on each rising edge of `rx_clk_in` once it has been synchronised. Any rate works when each clock phase lasts at least 2 system clocks, and the rate may change in the middle of a frame.
- R7: A `frame_end` pulse returns the engine to the search state one cycle later and discards any partial byte. Bits that follow are ignored until the start word matches again.
- R8: The FIFO holds 16 bytes and delivers them in arrival order. `rd_valid` is 1 exactly while it holds data. While `rd_valid`=1 and `rd_ready`=0, `rd_data` is held stable.
- R9: A byte that completes while the FIFO is full is dropped, and `ovf_flag` is set. `ovf_flag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Software receive enable |
| tx_busy | input | 1 | Transmit in progress; blocks reception |
| pwr_awake | input | 1 | Power state permits reception |
| frame_end | input | 1 | End-of-frame or abort pulse |
| rx_clk_in | input | 1 | Asynchronous receive bit clock from the PHY |
| rx_data_in | input | 1 | Serial receive data, valid at rising edges of `rx_clk_in` |
| rd_data | output | 8 | FIFO head byte |
| rd_valid | output | 1 | FIFO not empty; also acts as the DMA request |
| rd_ready | input | 1 | Consumer accepts the head byte |
| in_frame | output | 1 | Engine is in the data-accept state |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |

## Verification
Frames are sent with a preamble of alternating bits, the start word, and random payload bytes. The bit-clock half-periods are random between 2 and 6 system clocks. One frame switches rate after its first bytes, to show that sampling does not depend on a fixed rate. Directed frames cover the following cases, and each one isolates a single mechanism:
- a start word with one bit flipped, which tests match exactness;
- arming lost in the middle of a frame, and frames sent while not armed;
- a partial byte followed by `frame_end`, with later bits sent without a start word;
- 18 bytes sent with `rd_ready` held low, which tests the depth limit and the sticky overflow flag.

// File: rtl/rx_sfd_pkg.sv
package rx_sfd_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_ACCEPT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_clk_in,
  input  logic rx_data_in,
  output logic bit_stb,
  output logic bit_val
);
  logic [SYNC_STAGES:0]   clk_q;
  logic [SYNC_STAGES-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      dat_q <= '0;
    end else begin
      clk_q <= {clk_q[SYNC_STAGES-1:0], rx_clk_in};
      dat_q <= {dat_q[SYNC_STAGES-2:0], rx_data_in};
    end
  end

  // data taps the same age as the clock tap that shows the edge
  assign bit_stb = clk_q[SYNC_STAGES-1] & ~clk_q[SYNC_STAGES];
  assign bit_val = dat_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_sfd_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter logic [15:0] UWORD   = 16'hF3A0,
  parameter int          BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              frame_end,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              push,
  output logic [BYTE_W-1:0] push_data,
  output logic              in_frame
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_e         state;
  logic [WORD_W-1:0] hunt_sr;
  logic [WORD_W-1:0] hunt_nxt;
  logic [BYTE_W-1:0] byte_sr;
  logic [BYTE_W-1:0] byte_nxt;
  logic [CNT_W-1:0]  bit_cnt;
  logic              live;

  assign live     = armed && !frame_end;
  assign hunt_nxt = {bit_val, hunt_sr[WORD_W-1:1]};
  assign byte_nxt = {bit_val, byte_sr[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      hunt_sr <= '0;
      byte_sr <= '0;
      bit_cnt <= '0;
    end else if (!live) begin
      state   <= ST_HUNT;
      hunt_sr <= '0;
      bit_cnt <= '0;
    end else if (bit_stb) begin
      case (state)
        ST_HUNT: begin
          hunt_sr <= hunt_nxt;
          if (hunt_nxt == UWORD[WORD_W-1:0]) begin
            state   <= ST_ACCEPT;
            bit_cnt <= '0;
          end
        end
        default: begin
          byte_sr <= byte_nxt;
          bit_cnt <= bit_cnt + 1'b1;
        end
      endcase
    end
  end

  assign push      = live && bit_stb && (state == ST_ACCEPT) && (bit_cnt == LAST_BIT);
  assign push_data = byte_nxt;
  assign in_frame  = (state == ST_ACCEPT);
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              ovf_flag
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr;
  logic              full, empty, do_wr, do_rd;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_ready && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      if (wr_en && full) ovf_flag <= 1'b1;
    end
  end

  assign rd_valid = !empty;
  assign rd_data  = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/rx_sfd_capture.sv
module rx_sfd_capture #(
  parameter int          SYNC_STAGES = 2,
  parameter int          WORD_W      = 16,
  parameter logic [15:0] UWORD       = 16'hF3A0,
  parameter int          BYTE_W      = 8,
  parameter int          FIFO_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tx_busy,
  input  logic              pwr_awake,
  input  logic              frame_end,
  input  logic              rx_clk_in,
  input  logic              rx_data_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              in_frame,
  output logic              ovf_flag
);
  logic              bit_stb, bit_val, armed, push;
  logic [BYTE_W-1:0] push_data;

  assign armed = rx_en && !tx_busy && pwr_awake;

  rx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .rx_clk_in(rx_clk_in), .rx_data_in(rx_data_in),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  rx_frame_fsm #(.WORD_W(WORD_W), .UWORD(UWORD), .BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .armed(armed), .frame_end(frame_end),
    .bit_stb(bit_stb), .bit_val(bit_val),
    .push(push), .push_data(push_data), .in_frame(in_frame)
  );

  rx_byte_fifo #(.DATA_W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/rx_sfd_capture_chk.sv
module rx_sfd_capture_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              tx_busy,
  input logic              pwr_awake,
  input logic              frame_end,
  input logic [BYTE_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              in_frame,
  input logic              ovf_flag,
  input logic              bit_stb,
  input logic              push
);
  AST_NOT_ARMED_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && !tx_busy && pwr_awake) |=> !in_frame); // R2
  AST_ENTER_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(bit_stb)); // R3
  AST_PUSH_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> in_frame && bit_stb); // R4
  AST_END_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !in_frame); // R7
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R8
  AST_PUSH_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rd_valid); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R9
endmodule

bind rx_sfd_capture rx_sfd_capture_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_busy(tx_busy), .pwr_awake(pwr_awake),
  .frame_end(frame_end), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .in_frame(in_frame), .ovf_flag(ovf_flag), .bit_stb(bit_stb), .push(push)
);

// File: tb/rx_sfd_capture_tb.sv
module rx_sfd_capture_tb;
  localparam logic [15:0] UW = 16'hF3A0;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1, tx_busy = 1'b0, pwr_awake = 1'b1, frame_end = 1'b0;
  logic rx_clk_in = 1'b0, rx_data_in = 1'b0, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, in_frame, ovf_flag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  rx_sfd_capture u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_busy(tx_busy), .pwr_awake(pwr_awake),
    .frame_end(frame_end), .rx_clk_in(rx_clk_in), .rx_data_in(rx_data_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .in_frame(in_frame), .ovf_flag(ovf_flag)
  );

  function automatic int stored_count(int sent);
    return (sent > DEPTH) ? DEPTH : sent;
  endfunction

  function automatic bit expect_ovf(int sent);
    return sent > DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b, input int h);
    @(negedge clk);
    rx_data_in = b;
    rx_clk_in  = 1'b0;
    repeat (h) @(negedge clk);
    rx_clk_in = 1'b1;
    repeat (h - 1) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int h);
    for (int i = 0; i < 8; i++) send_bit(v[i], h);
  endtask

  task automatic send_word(input logic [15:0] w, input int h);
    for (int i = 0; i < 16; i++) send_bit(w[i], h);
  endtask

  task automatic preamble(input int n, input int h);
    for (int i = 0; i < n; i++) send_bit(i[0], h);
  endtask

  task automatic settle();
    @(negedge clk);
    rx_clk_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic end_frame();
    settle();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      @(negedge clk);
      chk(rd_valid === 1'b1, req, {31'd0, rd_valid}, 32'd1);
      chk(rd_data === e, req, {24'd0, rd_data}, {24'd0, e});
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    @(negedge clk);
    chk(rd_valid === 1'b0, {req, " empty after drain"}, {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_valid === 1'b0, "R1 rd_valid", {31'd0, rd_valid}, 0);
    chk(ovf_flag === 1'b0, "R1 ovf_flag", {31'd0, ovf_flag}, 0);
    chk(in_frame === 1'b0, "R1 in_frame", {31'd0, in_frame}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3/R4/R5 basic frame
    preamble(12, 3);
    chk(in_frame === 1'b0, "R4 still hunting in preamble", {31'd0, in_frame}, 0);
    send_word(UW, 3);
    settle();
    chk(in_frame === 1'b1, "R3 word matched", {31'd0, in_frame}, 1);
    chk(rd_valid === 1'b0, "R4 nothing stored before payload", {31'd0, rd_valid}, 0);
    foreach (exp_q[i]) ;
    exp_q.push_back(8'h01); exp_q.push_back(8'h80); exp_q.push_back(8'hC5);
    foreach (exp_q[i]) send_byte(exp_q[i], 3);
    end_frame();
    chk(in_frame === 1'b0, "R7 back to hunt", {31'd0, in_frame}, 0);
    drain("R5 LSB-first bytes");

    // R3 near miss: bit 5 flipped
    preamble(6, 2);
    send_word(UW ^ 16'h0020, 2);
    send_byte(8'h5A, 2);
    settle();
    chk(in_frame === 1'b0, "R3 near-miss rejected", {31'd0, in_frame}, 0);
    chk(rd_valid === 1'b0, "R3 near-miss stores nothing", {31'd0, rd_valid}, 0);
    end_frame();

    // R6 rate change mid frame
    preamble(8, 6);
    send_word(UW, 6);
    exp_q.push_back(8'h3C); exp_q.push_back(8'hE1);
    send_byte(8'h3C, 6);
    send_byte(8'hE1, 2);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      exp_q.push_back(v);
      send_byte(v, 2);
    end
    end_frame();
    drain("R6 rate switch");

    // R2 each arming condition off
    for (int m = 0; m < 3; m++) begin
      rx_en = (m != 0); tx_busy = (m == 1); pwr_awake = (m != 2);
      preamble(4, 2);
      send_word(UW, 2);
      send_byte(8'hAA, 2);
      settle();
      chk(in_frame === 1'b0, "R2 not armed in_frame", {31'd0, in_frame}, 0);
      chk(rd_valid === 1'b0, "R2 not armed no store", {31'd0, rd_valid}, 0);
      rx_en = 1'b1; tx_busy = 1'b0; pwr_awake = 1'b1;
      end_frame();
    end

    // R2 arming lost mid frame
    preamble(4, 2);
    send_word(UW, 2);
    send_byte(8'h96, 2);
    exp_q.push_back(8'h96);
    settle();
    tx_busy = 1'b1;
    send_byte(8'h11, 2);
    tx_busy = 1'b0;
    send_byte(8'h22, 2);
    settle();
    chk(in_frame === 1'b0, "R2 arm loss returns to hunt", {31'd0, in_frame}, 0);
    drain("R2 arm loss keeps only earlier byte");

    // R7 partial byte dropped, later bits ignored
    preamble(4, 3);
    send_word(UW, 3);
    send_byte(8'h7E, 3);
    exp_q.push_back(8'h7E);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 3);
    end_frame();
    send_byte(8'hFF, 3);
    send_byte(8'h00, 3);
    settle();
    chk(in_frame === 1'b0, "R7 ignored after end", {31'd0, in_frame}, 0);
    drain("R7 partial byte discarded");

    // R8/R9 overflow with back-pressure
    begin
      int sent;
      sent = 18;
      preamble(4, 2);
      send_word(UW, 2);
      for (int i = 0; i < sent; i++) begin
        logic [7:0] v;
        v = 8'($urandom);
        if (i < stored_count(sent)) exp_q.push_back(v);
        send_byte(v, 2);
      end
      end_frame();
      chk(ovf_flag === expect_ovf(sent), "R9 overflow set", {31'd0, ovf_flag}, {31'd0, expect_ovf(sent)});
      drain("R8 depth 16 in order");
      chk(ovf_flag === 1'b1, "R9 overflow sticky", {31'd0, ovf_flag}, 1);
    end

    // random frames (R5, R6, R8)
    for (int f = 0; f < 20; f++) begin
      int len, h;
      len = $urandom_range(1, 12);
      h = $urandom_range(2, 6);
      preamble($urandom_range(2, 20), h);
      send_word(UW, h);
      for (int i = 0; i < len; i++) begin
        logic [7:0] v;
        v = 8'($urandom);
        exp_q.push_back(v);
        send_byte(v, ($urandom_range(0, 3) == 0) ? $urandom_range(2, 6) : h);
      end
      end_frame();
      drain("R5 R6 random frame");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule